// File: doc/BRIEF.md
# Mask-Programmable Address Window Register

This block holds the configuration for one decoded address window. A writable mask register decides how large the window is and whether it decodes memory or I/O cycles. A companion base register holds where the window sits. Software writes the mask first and then the base. The base's read-only low bits report the window kind and its attributes, and these come from the mask.

A write to the mask has no effect on the base right away. The base keeps showing its old contents under the old mask until software writes the base again, even with the same value. That write captures the new mask. A pending flag in a status word shows that such a rewrite is still owed. A combinational `hit` output flags bus addresses inside the window that is currently applied.

The register port is a plain 32-bit bus with a word offset, a write strobe, four byte enables, write data and combinational read data. The offsets are: 0 for the mask, 1 for the base, 2 for the status word (bit 0 is the pending flag), and 3, which is unused. Reset is asynchronous and active low, and it is released in step with the clock through a two-stage synchronizer.

Top module: `maskbar_window`

## Requirements
- R1: After reset the mask reads the parameter MASK_RESET (default FFFFFFC1h). The stored base is 0, so the base reads its attribute bits only (00000001h for the default). The status word reads 0.
- R2: A mask write changes only the byte lanes whose enables are set. When mask bit 0 is 1 (I/O kind), mask bit 1 reads 0.
- R3: A mask write with any byte enabled sets status bit 0. A base write with any byte enabled clears it.
- R4: Between a mask write and the next base write, the base read value does not change.
- R5: After a base write, the base reads (stored & address bits of the applied mask) with the low bits taken from that mask. For a memory window (mask bit 0 = 0) the address bits are 31:4, and bits 3:0 copy mask bits 3:0 (bit 3 prefetchable, bits 2:1 type). For an I/O window the address bits are 31:2, and bits 1:0 read 01.
- R6: A base write updates only the stored byte lanes whose enables are set.
- R7: `hit` is 1 when ((bus_addr XOR base) AND address bits) is zero, provided the other conditions also hold.
- R8: `hit` is 0 unless `bus_is_io` equals bit 0 of the applied mask.
- R9: `hit` is 0 when the applied mask has no address bit set.
- R10: Offset 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| bus_addr | input | 32 | Address of a bus cycle to decode |
| bus_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| hit | output | 1 | Bus address falls inside the applied window |

## Verification
The assertions take for granted that the register inputs are known and stable around each clock edge whenever reset is released. They also assume a single write targets exactly one offset, so a mask write and a base write never happen in the same cycle. The stimulus changes inputs just after a rising edge, with one write per cycle and never during reset. For `hit`, only the combinational settling of `bus_addr` and `bus_is_io` against the applied window is assumed, and the bench samples it half a cycle after driving.

// File: rtl/maskbar_pkg.sv
package maskbar_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] OFS_MASK = 2'd0;
  localparam logic [REG_AW-1:0] OFS_BASE = 2'd1;
  localparam logic [REG_AW-1:0] OFS_STAT = 2'd2;

  localparam logic [WORD_W-1:0] MEM_ADDR_MASK = ~32'h0000_000F;
  localparam logic [WORD_W-1:0] IO_ADDR_MASK  = ~32'h0000_0003;

  function automatic logic [WORD_W-1:0] lane_merge(
      input logic [WORD_W-1:0] old_v,
      input logic [WORD_W-1:0] new_v,
      input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int i = 0; i < BE_W; i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] addr_bits_of(input logic [WORD_W-1:0] m);
    return m[0] ? (m & IO_ADDR_MASK) : (m & MEM_ADDR_MASK);
  endfunction

  function automatic logic [WORD_W-1:0] attr_bits_of(input logic [WORD_W-1:0] m);
    return m[0] ? 32'h0000_0001 : {28'h0, m[3:0]};
  endfunction
endpackage

// File: rtl/maskbar_rst_sync.sv
module maskbar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/maskbar_maskreg.sv
module maskbar_maskreg
  import maskbar_pkg::*;
#(
  parameter logic [WORD_W-1:0] MASK_RESET = 32'hFFFF_FFC1
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] mask_q
);
  logic [WORD_W-1:0] mask_d;
  logic [WORD_W-1:0] merged;
  logic              load;

  always_comb begin
    merged = lane_merge(mask_q, wdata, be);
    if (merged[0]) merged[1] = 1'b0;
    load   = wr_en && (|be);
    mask_d = merged;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)   mask_q <= MASK_RESET;
    else if (load) mask_q <= mask_d;
  end
endmodule

// File: rtl/maskbar_basereg.sv
module maskbar_basereg
  import maskbar_pkg::*;
#(
  parameter logic [WORD_W-1:0] MASK_RESET = 32'hFFFF_FFC1
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              base_wr,
  input  logic              mask_wr,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] mask_in,
  output logic [WORD_W-1:0] bar_value,
  output logic [WORD_W-1:0] addr_bits,
  output logic              pending
);
  logic [WORD_W-1:0] store_q, store_d;
  logic [WORD_W-1:0] act_q, act_d;
  logic              pend_d;
  logic              load;

  always_comb begin
    load    = base_wr && (|be);
    store_d = lane_merge(store_q, wdata, be);
    act_d   = mask_in;
    pend_d  = pending;
    if (mask_wr && (|be)) pend_d = 1'b1;
    if (load)             pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      store_q <= '0;
      act_q   <= MASK_RESET;
    end else if (load) begin
      store_q <= store_d;
      act_q   <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pending <= 1'b0;
    else         pending <= pend_d;
  end

  always_comb begin
    addr_bits = addr_bits_of(act_q);
    bar_value = (store_q & addr_bits) | attr_bits_of(act_q);
  end
endmodule

// File: rtl/maskbar_decode.sv
module maskbar_decode
  import maskbar_pkg::*;
(
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic [WORD_W-1:0] bar_value,
  input  logic [WORD_W-1:0] addr_bits,
  output logic              hit
);
  logic [WORD_W-1:0] diff;
  logic              enabled;
  logic              kind_ok;

  always_comb begin
    diff    = (bus_addr ^ bar_value) & addr_bits;
    enabled = |addr_bits;
    kind_ok = (bus_is_io == bar_value[0]);
    hit     = enabled && kind_ok && (diff == '0);
  end
endmodule

// File: rtl/maskbar_window.sv
module maskbar_window
  import maskbar_pkg::*;
#(
  parameter logic [31:0] MASK_RESET = 32'hFFFF_FFC1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] bus_addr,
  input  logic        bus_is_io,
  output logic        hit
);
  logic              rst_ns;
  logic              mask_wr;
  logic              base_wr;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] bar_value;
  logic [WORD_W-1:0] addr_bits;
  logic              pending;

  maskbar_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  always_comb begin
    mask_wr = reg_wr && (reg_addr == OFS_MASK);
    base_wr = reg_wr && (reg_addr == OFS_BASE);
  end

  maskbar_maskreg #(.MASK_RESET(MASK_RESET)) u_mask (
    .clk(clk), .rst_ns(rst_ns), .wr_en(mask_wr), .be(reg_be),
    .wdata(reg_wdata), .mask_q(mask_q)
  );

  maskbar_basereg #(.MASK_RESET(MASK_RESET)) u_base (
    .clk(clk), .rst_ns(rst_ns), .base_wr(base_wr), .mask_wr(mask_wr),
    .be(reg_be), .wdata(reg_wdata), .mask_in(mask_q),
    .bar_value(bar_value), .addr_bits(addr_bits), .pending(pending)
  );

  maskbar_decode u_dec (
    .bus_addr(bus_addr), .bus_is_io(bus_is_io), .bar_value(bar_value),
    .addr_bits(addr_bits), .hit(hit)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_MASK: reg_rdata = mask_q;
      OFS_BASE: reg_rdata = bar_value;
      OFS_STAT: reg_rdata = {31'h0, pending};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/maskbar_window_chk.sv
module maskbar_window_chk (
  input logic        clk,
  input logic        rst_ns,
  input logic        mask_wr,
  input logic        base_wr,
  input logic [3:0]  reg_be,
  input logic        bus_is_io,
  input logic [31:0] mask_q,
  input logic [31:0] bar_value,
  input logic        pending,
  input logic        hit
);
  assert_pending_set_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (mask_wr && (|reg_be)) |=> pending);

  assert_pending_clear_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (base_wr && (|reg_be)) |=> !pending);

  assert_base_held_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    !base_wr |=> $stable(bar_value));

  assert_mask_lane0_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (mask_wr && !reg_be[0]) |=> $stable(mask_q[7:0]));

  assert_hit_kind_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    hit |-> (bus_is_io == bar_value[0]));
endmodule

bind maskbar_window maskbar_window_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .mask_wr(mask_wr), .base_wr(base_wr),
  .reg_be(reg_be), .bus_is_io(bus_is_io), .mask_q(mask_q),
  .bar_value(bar_value), .pending(pending), .hit(hit)
);

// File: tb/maskbar_window_test.sv
module maskbar_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic        hit;

  typedef struct {
    bit          is_hit;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  probe = 1'b0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  maskbar_window uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .bus_is_io(bus_is_io), .hit(hit)
  );

  // monitor: pops the scoreboard at each falling edge while a probe is open
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_hit ? {31'h0, hit} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_hit = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic hchk(input logic [31:0] ad, input logic io, input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = ad; bus_is_io = io;
    it.is_hit = 1'b1; it.exp = {31'h0, e}; it.tag = tag;
    q.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    rd(2'd0, 32'hFFFF_FFC1, "R1 mask reset");
    rd(2'd1, 32'h0000_0001, "R1 base reset");
    rd(2'd2, 32'h0000_0000, "R1 status reset");
    hchk(32'h0000_0010, 1'b1, 1'b1, "R7 io hit at reset window");
    hchk(32'h0000_0010, 1'b0, 1'b0, "R8 memory cycle vs io window");

    // memory window 4 KB, prefetchable
    wr(2'd0, 4'hF, 32'hFFFF_F008);
    rd(2'd0, 32'hFFFF_F008, "R2 mask full write");
    rd(2'd2, 32'h0000_0001, "R3 pending after mask write");
    rd(2'd1, 32'h0000_0001, "R4 base unchanged before rewrite");
    wr(2'd1, 4'hF, 32'h1234_5678);
    rd(2'd2, 32'h0000_0000, "R3 pending cleared by base write");
    rd(2'd1, 32'h1234_5008, "R5 memory base with attributes");
    hchk(32'h1234_5ABC, 1'b0, 1'b1, "R7 memory hit inside");
    hchk(32'h1234_6000, 1'b0, 1'b0, "R7 memory miss outside");
    hchk(32'h1234_5ABC, 1'b1, 1'b0, "R8 io cycle vs memory window");

    // byte lanes on base
    wr(2'd1, 4'b1000, 32'hAB00_0000);
    rd(2'd1, 32'hAB34_5008, "R6 top lane only");
    wr(2'd1, 4'b0001, 32'h0000_00FF);
    rd(2'd1, 32'hAB34_5008, "R6 low lane masked off");
    wr(2'd1, 4'b0010, 32'h0000_CD00);
    rd(2'd1, 32'hAB34_C008, "R6 lane one");

    // mask lane write switching to io, bit1 cleared
    wr(2'd0, 4'b0001, 32'h0000_0007);
    rd(2'd0, 32'hFFFF_F005, "R2 lane write and io bit1 zero");
    rd(2'd2, 32'h0000_0001, "R3 pending after lane write");
    rd(2'd1, 32'hAB34_C008, "R4 stale base held");
    wr(2'd1, 4'hF, 32'h0000_1234);
    rd(2'd1, 32'h0000_1005, "R5 io base with attributes");
    hchk(32'h0000_1007, 1'b1, 1'b1, "R7 io hit");
    hchk(32'h0000_1000, 1'b1, 1'b0, "R7 io miss");

    // disabled window
    wr(2'd0, 4'hF, 32'h0000_0000);
    wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0000_0000, "R9 base with zero mask");
    hchk(32'h0000_0000, 1'b0, 1'b0, "R9 no hit with zero mask");

    // unused offset
    wr(2'd3, 4'hF, 32'hDEAD_BEEF);
    rd(2'd3, 32'h0000_0000, "R10 unused offset reads zero");
    rd(2'd0, 32'h0000_0000, "R10 mask untouched");
    rd(2'd1, 32'h0000_0000, "R10 base untouched");
    rd(2'd2, 32'h0000_0000, "R10 status untouched");

    repeat (2) @(posedge clk);
    if (q.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule